// File: doc/BRIEF.md
# 100 Mb/s Symbol-to-Nibble Receive Decoder

This block sits behind the code-group aligner of a 100 Mb/s receive path. Each clock it takes one aligned 5-bit code group. It produces the receive side of a media-independent interface: a data nibble, a data-valid flag, a receive-error flag and carrier sense. Frame boundaries come from control-symbol pairs. A /J/ followed by /K/ opens a frame. Either /T/ followed by /R/, or two IDLE groups in a row, closes it. A closing symbol that arrives without its partner does not end the frame.

The block decides on each symbol only after it has seen the next one. For this reason the outputs for the code group applied before clock edge n appear after edge n+1. The two delimiter symbols leave the block as two preamble nibbles (0101) with data-valid high. Data code groups leave as their nibbles. Malformed content inside a frame raises the error flag on the slot where it occurs.

Top module: `sdec_rx_top`

## Requirements
- R1: While rst_n is low, and from the moment it falls, crs, rx_dv and rx_er are low and rxd is 0000. After release the block is idle and waits for a start pair.
- R2: Inside a frame each data code group is output as its nibble with rx_dv high and rx_er low. The mapping for nibbles 0 to F is: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: A 11000 (/J/) immediately followed by 10001 (/K/) starts a frame. The output slots of both symbols show crs=1, rx_dv=1 and rxd=0101. The output for a symbol appears two clock edges after it is applied.
- R4: A /J/ that is not immediately followed by /K/ leaves the block idle, with all outputs low.
- R5: Inside a frame, 01101 (/T/) immediately followed by 00111 (/R/) ends the frame. crs and rx_dv are already low in the /T/ slot, and the /R/ slot is all low.
- R6: A /T/ inside a frame that is not followed by /R/ keeps crs and rx_dv high and raises rx_er in its slot.
- R7: Inside a frame, two consecutive 11111 (IDLE) groups end the frame. crs and rx_dv are low from the first IDLE slot onward.
- R8: A single IDLE inside a frame that is followed by a non-IDLE group keeps crs and rx_dv high and raises rx_er in its slot.
- R9: An /R/ that does not directly follow a frame-ending /T/ raises rx_er in its slot, both inside and outside a frame. Outside a frame, crs and rx_dv stay low.
- R10: 00100 (/H/) raises rx_er in its slot, both inside and outside a frame.
- R11: Any code group outside the data, IDLE and /J/ /K/ /T/ /R/ /H/ set (for example 00110, 11001, 00000) raises rx_er only while rx_dv is high. Outside a frame it has no effect on any output.
- R12: rxd is 0000 in every slot where rx_dv is low, and in every error slot that is not a data code group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, one code group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_in | input | 5 | Aligned 5-bit code group |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |

## Verification
The embedded properties check several behaviours on every cycle:
- data-valid never appears without carrier;
- every carrier rise is followed by exactly two preamble slots;
- carrier only falls when the symbol being retired is /T/ or IDLE;
- the nibble is quiet whenever data-valid is low;
- an error outside a frame can only come from /R/ or /H/.

Other behaviours depend on particular symbol sequences, so only the bench scenarios can show them:
- that each data code group maps to the correct nibble;
- that a lone /T/ or lone IDLE keeps carrier;
- that an orphan /J/ is ignored;
- that invalid groups are silent outside a frame;
- the exact two-edge latency.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;

  // control code groups whose values drive the frame logic
  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CG_H    = 5'b00100;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  typedef enum logic [2:0] {
    SK_DATA, SK_IDLE, SK_J, SK_K, SK_T, SK_R, SK_H, SK_BAD
  } sym_kind_e;

  typedef enum logic [1:0] {
    FS_IDLE, FS_SECOND, FS_BODY, FS_DROP_R
  } frm_state_e;

endpackage

// File: rtl/sdec_sym_lookup.sv
module sdec_sym_lookup
  import sdec_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = NIB_W
) (
  input  logic [CW-1:0]   code,
  output sym_kind_e       kind,
  output logic [NW-1:0]   nib
);

  // R2: data code group to nibble mapping; everything unknown is SK_BAD (R11)
  always_comb begin
    kind = SK_DATA;
    nib  = '0;
    case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      CG_IDLE:  kind = SK_IDLE;
      CG_J:     kind = SK_J;
      CG_K:     kind = SK_K;
      CG_T:     kind = SK_T;
      CG_R:     kind = SK_R;
      CG_H:     kind = SK_H;
      default:  kind = SK_BAD;
    endcase
  end

endmodule

// File: rtl/sdec_frame_fsm.sv
module sdec_frame_fsm
  import sdec_pkg::*;
#(
  parameter int NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sym_kind_e     cur_kind,
  input  logic [NW-1:0] cur_nib,
  output logic [NW-1:0] rxd,
  output logic          rx_dv,
  output logic          rx_er,
  output logic          crs
);

  // one-symbol lookahead stage
  sym_kind_e     prev_kind_q;
  logic [NW-1:0] prev_nib_q;

  frm_state_e    state_q, state_d;
  logic          crs_q, crs_d;
  logic          dv_q, dv_d;
  logic          er_q, er_d;
  logic [NW-1:0] rxd_q, rxd_d;

  // next-state and output decision for the symbol held in prev_*
  always_comb begin
    state_d = state_q;
    crs_d   = 1'b0;
    dv_d    = 1'b0;
    er_d    = 1'b0;
    rxd_d   = '0;
    case (state_q)
      FS_IDLE: begin
        if (prev_kind_q == SK_J && cur_kind == SK_K) begin
          state_d = FS_SECOND;
          crs_d   = 1'b1;
          dv_d    = 1'b1;
          rxd_d   = PRE_NIB;
        end else if (prev_kind_q == SK_R || prev_kind_q == SK_H) begin
          er_d = 1'b1;
        end
      end
      FS_SECOND: begin
        state_d = FS_BODY;
        crs_d   = 1'b1;
        dv_d    = 1'b1;
        rxd_d   = PRE_NIB;
      end
      FS_BODY: begin
        crs_d = 1'b1;
        dv_d  = 1'b1;
        case (prev_kind_q)
          SK_DATA: rxd_d = prev_nib_q;
          SK_T: begin
            if (cur_kind == SK_R) begin
              crs_d   = 1'b0;
              dv_d    = 1'b0;
              state_d = FS_DROP_R;
            end else begin
              er_d = 1'b1;
            end
          end
          SK_IDLE: begin
            if (cur_kind == SK_IDLE) begin
              crs_d   = 1'b0;
              dv_d    = 1'b0;
              state_d = FS_IDLE;
            end else begin
              er_d = 1'b1;
            end
          end
          default: er_d = 1'b1;
        endcase
      end
      FS_DROP_R: state_d = FS_IDLE;
      default:   state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_kind_q <= SK_IDLE;
      prev_nib_q  <= '0;
      state_q     <= FS_IDLE;
      crs_q       <= 1'b0;
      dv_q        <= 1'b0;
      er_q        <= 1'b0;
      rxd_q       <= '0;
    end else begin
      prev_kind_q <= cur_kind;
      prev_nib_q  <= cur_nib;
      state_q     <= state_d;
      crs_q       <= crs_d;
      dv_q        <= dv_d;
      er_q        <= er_d;
      rxd_q       <= rxd_d;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign rx_er = er_q;
  assign crs   = crs_q;

  AST_DV_NEEDS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> crs_q); // R3
  AST_SOF_FIRST_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_q) |-> (dv_q && rxd_q == PRE_NIB)); // R3
  AST_SOF_SECOND_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_q) |=> (dv_q && rxd_q == PRE_NIB)); // R3
  AST_CRS_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs_q) |-> ($past(prev_kind_q) == SK_T || $past(prev_kind_q) == SK_IDLE)); // R5
  AST_QUIET_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dv_q |-> (rxd_q == '0)); // R12
  AST_OUTSIDE_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (er_q && !dv_q) |-> ($past(prev_kind_q) == SK_R || $past(prev_kind_q) == SK_H)); // R9

endmodule

// File: rtl/sdec_rx_top.sv
module sdec_rx_top
  import sdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  code_in,
  output logic [3:0]  rxd,
  output logic        rx_dv,
  output logic        rx_er,
  output logic        crs
);

  sym_kind_e         cur_kind;
  logic [NIB_W-1:0]  cur_nib;

  sdec_sym_lookup #(.CW(CODE_W), .NW(NIB_W)) u_lookup (
    .code (code_in),
    .kind (cur_kind),
    .nib  (cur_nib)
  );

  sdec_frame_fsm #(.NW(NIB_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_kind (cur_kind),
    .cur_nib  (cur_nib),
    .rxd      (rxd),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .crs      (crs)
  );

endmodule

// File: tb/sdec_rx_top_test.sv
module sdec_rx_top_test;

  logic       clk;
  logic       rst_n;
  logic [4:0] code_in;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, crs;

  int n_chk;
  int n_bad;
  bit done;

  sdec_rx_top uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111, H = 5'b00100;
  localparam int NV = 52;
  // {code, crs, dv, er, rxd, requirement number}
  localparam logic [15:0] VEC [NV] = '{
    {I, 3'b000, 4'h0, 4'd12},         // R12
    {I, 3'b000, 4'h0, 4'd12},
    {J, 3'b110, 4'h5, 4'd3},          // R3
    {K, 3'b110, 4'h5, 4'd3},
    {5'b11110, 3'b110, 4'h0, 4'd2},   // R2
    {5'b01001, 3'b110, 4'h1, 4'd2},
    {5'b10100, 3'b110, 4'h2, 4'd2},
    {5'b10101, 3'b110, 4'h3, 4'd2},
    {5'b01010, 3'b110, 4'h4, 4'd2},
    {5'b01011, 3'b110, 4'h5, 4'd2},
    {5'b01110, 3'b110, 4'h6, 4'd2},
    {5'b01111, 3'b110, 4'h7, 4'd2},
    {5'b10010, 3'b110, 4'h8, 4'd2},
    {5'b10011, 3'b110, 4'h9, 4'd2},
    {5'b10110, 3'b110, 4'hA, 4'd2},
    {5'b10111, 3'b110, 4'hB, 4'd2},
    {5'b11010, 3'b110, 4'hC, 4'd2},
    {5'b11011, 3'b110, 4'hD, 4'd2},
    {5'b11100, 3'b110, 4'hE, 4'd2},
    {5'b11101, 3'b110, 4'hF, 4'd2},
    {T, 3'b000, 4'h0, 4'd5},          // R5
    {R, 3'b000, 4'h0, 4'd5},
    {I, 3'b000, 4'h0, 4'd5},
    {I, 3'b000, 4'h0, 4'd5},
    {J, 3'b110, 4'h5, 4'd3},
    {K, 3'b110, 4'h5, 4'd3},
    {5'b01011, 3'b110, 4'h5, 4'd2},
    {T, 3'b111, 4'h0, 4'd6},          // R6
    {5'b01111, 3'b110, 4'h7, 4'd6},
    {H, 3'b111, 4'h0, 4'd10},         // R10
    {R, 3'b111, 4'h0, 4'd9},          // R9
    {5'b00110, 3'b111, 4'h0, 4'd11},  // R11
    {5'b11001, 3'b111, 4'h0, 4'd11},
    {5'b00000, 3'b111, 4'h0, 4'd11},
    {I, 3'b111, 4'h0, 4'd8},          // R8
    {5'b10110, 3'b110, 4'hA, 4'd8},
    {I, 3'b000, 4'h0, 4'd7},          // R7
    {I, 3'b000, 4'h0, 4'd7},
    {5'b00110, 3'b000, 4'h0, 4'd11},
    {5'b11001, 3'b000, 4'h0, 4'd11},
    {H, 3'b001, 4'h0, 4'd10},
    {R, 3'b001, 4'h0, 4'd9},
    {J, 3'b000, 4'h0, 4'd4},          // R4
    {5'b00110, 3'b000, 4'h0, 4'd4},
    {J, 3'b000, 4'h0, 4'd4},
    {J, 3'b110, 4'h5, 4'd3},
    {K, 3'b110, 4'h5, 4'd3},
    {5'b11101, 3'b110, 4'hF, 4'd2},
    {T, 3'b000, 4'h0, 4'd5},
    {R, 3'b000, 4'h0, 4'd5},
    {I, 3'b000, 4'h0, 4'd12},
    {I, 3'b000, 4'h0, 4'd12}
  };

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {crs, rx_dv, rx_er, rxd};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {crs,dv,er,rxd} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [4:0] c);
    @(negedge clk);
    code_in = c;
  endtask

  initial begin
    rst_n   = 1'b0;
    code_in = I;
    repeat (3) @(negedge clk);
    chk("R1", 7'b000_0000);             // R1 reset state
    rst_n = 1'b1;

    // table walk: output of symbol m-2 checked at negedge m
    for (int m = 0; m < NV + 2; m++) begin
      @(negedge clk);
      if (m >= 2) begin
        string tag;
        tag = $sformatf("R%0d", VEC[m-2][3:0]);
        chk(tag, VEC[m-2][10:4]);
      end
      code_in = (m < NV) ? VEC[m][15:11] : I;
    end

    // R3 latency: J then K, outputs change exactly two edges later
    send(J);
    send(K);
    chk("R3 before", 7'b000_0000);
    send(5'b10100);
    chk("R3 after", 7'b110_0101);
    send(5'b10101);
    chk("R3 second", 7'b110_0101);
    @(negedge clk);
    chk("R2 nibble", 7'b110_0010);

    // R1 asynchronous reset in the middle of a frame
    #1 rst_n = 1'b0;
    #1 chk("R1 async", 7'b000_0000);
    @(negedge clk);
    code_in = I;
    rst_n = 1'b1;
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      chk("R1 idle after", 7'b000_0000);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule